// File: doc/BRIEF.md
# NAND Flash Operation Launch and Completion Unit

This block is the register-facing front of a NAND flash controller. Software sets up a command value, an address byte and a buffer/chip-select word in their own 16-bit registers. It then launches one flash bus operation by writing a start bit into the operation register. The unit holds a request towards the flash-bus timing engine until that engine returns a single-cycle done pulse. It then raises a sticky completion flag, which drives a level interrupt unless the interrupt is masked.

The configuration register holds the interrupt mask, the transfer byte order, the full-page interrupt mode and the chip-enable bit. It also holds a self-clearing soft reset. The soft reset stays set for a fixed number of cycles and then returns the operation and configuration state to their defaults. The registers are reached over a simple word-select write port with a combinational read.

Top module: `nand_op_trigger`

## Requirements
- R1: After reset the operation register (select 0) reads 0x0000, the configuration register (select 1) reads 0x0010 (interrupt masked), `irq` is 0 and `eng_req` is 0.
- R2: A write to select 0 while idle starts an operation. The start bits are bit0 command, bit1 address, bit2 page data in, bit3 page data out, bit4 ID read and bit5 status read. One cycle after the write, `eng_req` is 1, `eng_op` carries the chosen bit, and select 0 reads that bit back while the operation runs.
- R3: When several start bits are written together, only the lowest-numbered one is launched.
- R4: A start write made while an operation is running is ignored. A write to select 0 with none of bits [5:0] set launches nothing.
- R5: A done pulse during an operation ends it. One cycle later `eng_req` is 0, bits [5:0] of select 0 read 0, and bit 15 (completion flag) reads 1.
- R6: The completion flag is cleared only by writing select 0 with bit 15 at 0. Writing bit 15 as 1 leaves it set. A done pulse in the same cycle as a clearing write leaves it set.
- R7: `irq` is 1 exactly when the completion flag is 1 and configuration bit 4 is 0.
- R8: Configuration bits 4 (interrupt mask), 5 (big-endian, `big_endian`), 7 (chip enable, `chip_en`) and 11 (full-page interrupt, `page_irq_mode`) are writable and read back. All other bits except bit 6 read 0.
- R9: Writing configuration bit 6 as 1 starts a soft reset. Bit 6 then reads 1 for exactly RST_CYCLES cycles and clears itself. The reset aborts any running operation. After it, select 0 reads 0x0000 and select 1 reads 0x0010.
- R10: The buffer address register (select 2) holds the chip select in bits [6:5], which drive `chip_sel`, and the buffer index in bits [2:0], which drive `eng_buf`. Its other bits read 0.
- R11: The command register (select 3) and the address register (select 4) are read back and drive `eng_cmd` and `eng_adr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select (0 op, 1 config, 2 buffer, 3 command, 4 address) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_sel` |
| eng_req | output | 1 | Operation request to the timing engine |
| eng_op | output | 6 | One-hot operation being requested |
| eng_cmd | output | 16 | Command value |
| eng_adr | output | 16 | Address value |
| eng_buf | output | 3 | RAM buffer index |
| eng_done | input | 1 | Single-cycle completion pulse from the engine |
| chip_en | output | 1 | Chip enable |
| chip_sel | output | 2 | Active chip select |
| big_endian | output | 1 | Byte order select |
| page_irq_mode | output | 1 | Full-page interrupt mode |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check four things. The launched operation stays one-hot and stable while the engine has not answered. A done pulse always produces the flag and, when unmasked, the interrupt. The flag never drops without a clearing write or a soft reset. A soft reset always ends with default registers. Only the bench scenarios show the rest: that the right start bit is chosen for each written pattern, the exact length of the soft reset, the read-back masking of the configuration and buffer registers, and the same-cycle race between a clearing write and a done pulse.

// File: rtl/nand_trig_pkg.sv
package nand_trig_pkg;
    localparam int OP_W     = 6;
    localparam int DW       = 16;
    localparam int FLAG_BIT = 15;
    localparam int CFG_MASK = 4;
    localparam int CFG_BE   = 5;
    localparam int CFG_SRST = 6;
    localparam int CFG_CE   = 7;
    localparam int CFG_FPI  = 11;
    localparam logic [DW-1:0] CFG_DEFAULT = 16'h0010;
    localparam logic [DW-1:0] CFG_WMASK   = 16'h08B0;
    localparam logic [DW-1:0] BUF_WMASK   = 16'h0067;

    typedef enum logic [2:0] {
        SEL_OP  = 3'd0,
        SEL_CFG = 3'd1,
        SEL_BUF = 3'd2,
        SEL_CMD = 3'd3,
        SEL_ADR = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic            busy;
        logic            flag;
        logic [OP_W-1:0] op;
    } seq_st_t;
endpackage

// File: rtl/nand_trig_opsel.sv
module nand_trig_opsel #(
    parameter int W = 6
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant
);
    logic [W:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_pick
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    always_comb begin
        // R3
        onehot_grant_chk: assert ($onehot0(grant));
    end
endmodule

// File: rtl/nand_trig_seq.sv
module nand_trig_seq
    import nand_trig_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_clr,
    input  logic            soft_busy,
    input  logic            op_wr,
    input  logic [DW-1:0]   wdata,
    input  logic            eng_done,
    output logic            busy,
    output logic            flag,
    output logic [OP_W-1:0] op
);
    seq_st_t         st_d, st_q;
    logic [OP_W-1:0] grant;

    nand_trig_opsel #(.W(OP_W)) opsel_i (
        .req   (wdata[OP_W-1:0]),
        .grant (grant)
    );

    always_comb begin
        st_d = st_q;
        if (soft_clr) begin
            st_d = '0;
        end else if (!soft_busy) begin
            if (op_wr) begin
                if (!wdata[FLAG_BIT]) st_d.flag = 1'b0;
                if (!st_q.busy && (|grant)) begin
                    st_d.busy = 1'b1;
                    st_d.op   = grant;
                end
            end
            if (st_q.busy && eng_done) begin
                st_d.busy = 1'b0;
                st_d.op   = '0;
                st_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign flag = st_q.flag;
    assign op   = st_q.op;

    // R2
    busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot(op));
    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done && !soft_busy) |=> (busy && $stable(op)));
    // R5
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && !soft_busy) |=> (flag && !busy));
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(op_wr && !wdata[FLAG_BIT]) && !soft_clr) |=> flag);
endmodule

// File: rtl/nand_trig_rstctl.sv
module nand_trig_rstctl #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic clr
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rst_st_t;

    rst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
        else if (start)      st_d.cnt = CW'(RST_CYCLES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);
    assign clr    = (st_q.cnt == CW'(1));

    // R9
    rst_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active) |=> active);
    // R9
    rst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !active);
endmodule

// File: rtl/nand_op_trigger.sv
module nand_op_trigger
    import nand_trig_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [2:0]    bus_sel,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic          eng_req,
    output logic [5:0]    eng_op,
    output logic [15:0]   eng_cmd,
    output logic [15:0]   eng_adr,
    output logic [2:0]    eng_buf,
    input  logic          eng_done,
    output logic          chip_en,
    output logic [1:0]    chip_sel,
    output logic          big_endian,
    output logic          page_irq_mode,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] cfg;
        logic [DW-1:0] bufa;
        logic [DW-1:0] cmd;
        logic [DW-1:0] adr;
    } regs_t;

    regs_t           rg_d, rg_q;
    logic            rst_active, rst_clr, rst_start;
    logic            op_wr, busy, flag;
    logic [OP_W-1:0] op;

    assign op_wr     = bus_wr && (bus_sel == SEL_OP);
    assign rst_start = bus_wr && (bus_sel == SEL_CFG) && bus_wdata[CFG_SRST];

    nand_trig_rstctl #(.RST_CYCLES(RST_CYCLES)) rstctl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rst_start),
        .active (rst_active),
        .clr    (rst_clr)
    );

    nand_trig_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (rst_clr),
        .soft_busy (rst_active),
        .op_wr     (op_wr),
        .wdata     (bus_wdata),
        .eng_done  (eng_done),
        .busy      (busy),
        .flag      (flag),
        .op        (op)
    );

    always_comb begin
        rg_d = rg_q;
        if (bus_wr) begin
            unique case (bus_sel)
                SEL_CFG: if (!rst_active) rg_d.cfg = bus_wdata & CFG_WMASK;
                SEL_BUF: rg_d.bufa = bus_wdata & BUF_WMASK;
                SEL_CMD: rg_d.cmd  = bus_wdata;
                SEL_ADR: rg_d.adr  = bus_wdata;
                default: ;
            endcase
        end
        if (rst_clr) rg_d.cfg = CFG_DEFAULT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q     <= '0;
            rg_q.cfg <= CFG_DEFAULT;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_sel)
            SEL_OP: begin
                bus_rdata[OP_W-1:0] = op;
                bus_rdata[FLAG_BIT] = flag;
            end
            SEL_CFG: begin
                bus_rdata           = rg_q.cfg;
                bus_rdata[CFG_SRST] = rst_active;
            end
            SEL_BUF: bus_rdata = rg_q.bufa;
            SEL_CMD: bus_rdata = rg_q.cmd;
            SEL_ADR: bus_rdata = rg_q.adr;
            default: bus_rdata = '0;
        endcase
    end

    assign eng_req       = busy;
    assign eng_op        = op;
    assign eng_cmd       = rg_q.cmd;
    assign eng_adr       = rg_q.adr;
    assign eng_buf       = rg_q.bufa[2:0];
    assign chip_sel      = rg_q.bufa[6:5];
    assign chip_en       = rg_q.cfg[CFG_CE];
    assign big_endian    = rg_q.cfg[CFG_BE];
    assign page_irq_mode = rg_q.cfg[CFG_FPI];
    assign irq           = flag & ~rg_q.cfg[CFG_MASK];

    // R7
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && !rst_active && !rg_q.cfg[CFG_MASK] && !rst_start
         && !(bus_wr && bus_sel == SEL_CFG)) |=> irq);
    // R9
    srst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_clr |=> (!eng_req && !flag && (rg_q.cfg == CFG_DEFAULT)));
endmodule

// File: tb/nand_op_trigger_tb_top.sv
`timescale 1ns/1ps
module nand_op_trigger_tb_top;
    localparam int RSTC = 4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        eng_req, eng_done = 1'b0;
    logic [5:0]  eng_op;
    logic [15:0] eng_cmd, eng_adr;
    logic [2:0]  eng_buf;
    logic        chip_en, big_endian, page_irq_mode, irq;
    logic [1:0]  chip_sel;
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    nand_op_trigger #(.RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_req(eng_req),
        .eng_op(eng_op), .eng_cmd(eng_cmd), .eng_adr(eng_adr), .eng_buf(eng_buf),
        .eng_done(eng_done), .chip_en(chip_en), .chip_sel(chip_sel),
        .big_endian(big_endian), .page_irq_mode(page_irq_mode), .irq(irq)
    );

    localparam int NV = 10;
    localparam logic [15:0] VW [NV] = '{16'h0001, 16'h0002, 16'h0004, 16'h0008,
        16'h0010, 16'h0020, 16'h0006, 16'h0030, 16'h003F, 16'h8028};
    localparam logic [15:0] VE [NV] = '{16'h0001, 16'h0002, 16'h0004, 16'h0008,
        16'h0010, 16'h0020, 16'h0002, 16'h0010, 16'h0001, 16'h0008};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [15:0] d);
        bus_sel = sel;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic done_pulse();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd0, r); chk("R1 op reg", r, 16'h0000);
        rd(3'd1, r); chk("R1 cfg reg", r, 16'h0010);
        chk("R1 irq", {15'd0, irq}, 16'h0);
        chk("R1 eng_req", {15'd0, eng_req}, 16'h0);

        // R11 command and address registers
        wr(3'd3, 16'h0030); wr(3'd4, 16'h00A5);
        chk("R11 eng_cmd", eng_cmd, 16'h0030);
        chk("R11 eng_adr", eng_adr, 16'h00A5);
        rd(3'd4, r); chk("R11 adr readback", r, 16'h00A5);

        // unmask interrupt
        wr(3'd1, 16'h0000);
        // R2 R3 R5 R7 vector walk
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, VW[i]);
            chk("R2/R3 eng_op", {10'd0, eng_op}, VE[i]);
            chk("R2 eng_req", {15'd0, eng_req}, 16'h1);
            rd(3'd0, r); chk("R2 op readback", r, VE[i]);
            done_pulse();
            chk("R5 req drop", {15'd0, eng_req}, 16'h0);
            rd(3'd0, r); chk("R5 flag set", r, 16'h8000);
            chk("R7 irq unmasked", {15'd0, irq}, 16'h1);
            wr(3'd0, 16'h0000);
            chk("R6 flag clear irq", {15'd0, irq}, 16'h0);
        end

        // R4 start while busy ignored
        wr(3'd0, 16'h0001);
        wr(3'd0, 16'h0008);
        chk("R4 busy ignore", {10'd0, eng_op}, 16'h0001);
        done_pulse();
        // R6 writing bit15=1 keeps flag
        wr(3'd0, 16'h8000);
        rd(3'd0, r); chk("R6 write one keeps", r, 16'h8000);
        // R7 mask
        wr(3'd1, 16'h0010);
        chk("R7 masked irq", {15'd0, irq}, 16'h0);
        wr(3'd1, 16'h0000);
        chk("R7 unmasked irq", {15'd0, irq}, 16'h1);
        wr(3'd0, 16'h0000);
        // R6 done wins over same-cycle clear
        wr(3'd0, 16'h0002);
        bus_wr = 1'b1; bus_sel = 3'd0; bus_wdata = 16'h0000; eng_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; eng_done = 1'b0;
        rd(3'd0, r); chk("R6 done wins", r, 16'h8000);
        wr(3'd0, 16'h0000);
        // R4 no start bits
        wr(3'd0, 16'h0040);
        chk("R4 no start", {15'd0, eng_req}, 16'h0);

        // R8 config bits
        wr(3'd1, 16'hFFBF);
        rd(3'd1, r); chk("R8 cfg readback", r, 16'h08B0);
        chk("R8 outputs", {13'd0, chip_en, big_endian, page_irq_mode}, 16'h0007);

        // R10 buffer register
        wr(3'd2, 16'hFFFF);
        rd(3'd2, r); chk("R10 buf readback", r, 16'h0067);
        chk("R10 outputs", {11'd0, chip_sel, eng_buf}, 16'h001F);
        wr(3'd2, 16'h0040);
        chk("R10 cs only", {11'd0, chip_sel, eng_buf}, 16'h0010);

        // R9 soft reset aborts running op and restores defaults
        wr(3'd0, 16'h0004);
        wr(3'd1, 16'h00C0);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            rd(3'd1, r);
            if (!r[6]) break;
            n++;
            @(negedge clk);
        end
        chk("R9 reset length", 16'(n), 16'(RSTC));
        rd(3'd1, r); chk("R9 cfg default", r, 16'h0010);
        rd(3'd0, r); chk("R9 op cleared", r, 16'h0000);
        chk("R9 req dropped", {15'd0, eng_req}, 16'h0);
        chk("R9 irq low", {15'd0, irq}, 16'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule